// File: doc/BRIEF.md
# Whole-Chip Erase Sequencer with Resumable Verify

This controller sits inside a device programmer and erases a reprogrammable EPROM with a closed loop. After a start request it skips any pre-write of zeros and goes straight to the first erase pulse. During that pulse the programmer's high-voltage enables for the A9 pin and the programming supply are on, and chip enable is held low for a parameterised number of clock cycles. The controller then reads the array in ascending order and expects every byte to read FFh. The highest address to check is given with the start request.

When a byte does not read FFh, verification stops at once and the whole chip receives another pulse. The failing address stays in the address cursor, so the next verify pass begins at that byte and does not go back to zero. Once a pass reaches the highest address cleanly, the controller reports success, the number of pulses used and an idle pin port. If a byte still fails after the largest allowed number of pulses, it reports failure instead. An abort input forces the pins to idle in the next cycle.

The sequencer has six states. In `ST_IDLE` the pins are idle, and a start request leads to `ST_HV_SETUP`. In `ST_HV_SETUP` A9 and VPP high voltage are on with CE high, for SETUP_CYC cycles, then `ST_PULSE` follows. In `ST_PULSE` CE is low for PULSE_CYC cycles, then `ST_HV_HOLD` follows. In `ST_HV_HOLD` CE is high and A9 stays high for HOLD_CYC cycles, then `ST_ADDR_SETUP` follows. In `ST_ADDR_SETUP` A9 is at logic level, VPP is high, CE is low, OE is high and the address is held for SETUP_CYC cycles, then `ST_READ` follows. `ST_READ` lasts one cycle with OE low and has three exits. If the byte reads FFh and is below the last address, it goes to `ST_ADDR_SETUP` with the next address. If the byte reads FFh at the last address, it goes to `ST_IDLE` with a pass. If the byte fails, it goes to `ST_HV_SETUP` while pulses remain, or to `ST_IDLE` with a fail once they are used up. From any state, abort leads to `ST_IDLE`.

Top module: `chip_erase_sequencer`

## Requirements
- R1: After reset the pin port is idle: ce_n=1, oe_n=1, both high-voltage enables 0. busy_o, done_o, pass_o and pulse_cnt_o are all 0.
- R2: One cycle after start_i is accepted, busy_o=1, pulse_cnt_o=0, A9 and VPP high voltage are on and CE is high. No CE-low or OE-low cycle occurs before the first erase pulse.
- R3: Each erase pulse holds CE low for exactly PULSE_CYC cycles. A9 and VPP high voltage are on and OE is high for the whole pulse. pulse_cnt_o rises by one per pulse.
- R4: A9 high voltage is on with CE high for at least SETUP_CYC cycles before CE falls for a pulse. It stays on with CE high for at least HOLD_CYC cycles after CE rises. A9 only turns on while CE is high.
- R5: During verify, A9 high voltage is off, VPP is on and CE is low. The address is held stable for at least SETUP_CYC cycles before OE falls. The data is judged during the single OE-low cycle.
- R6: The first verify pass after start begins at address 0. Within a pass, each read uses the previous address plus one.
- R7: A byte that is not FFh ends the pass and triggers another erase pulse. The next pass begins at that same address.
- R8: When the byte at last_addr_i (captured at start) reads FFh, done_o=1 and pass_o=1. pulse_cnt_o then holds the number of pulses used, busy_o=0 and the pin port is idle.
- R9: When a byte fails and MAX_PULSES pulses have been applied, done_o=1 and pass_o=0 with pulse_cnt_o=MAX_PULSES, and no further pulse is applied. A pass reached on exactly the last allowed pulse reports success.
- R10: abort_i makes the pin port idle and sets busy_o=0 and done_o=0 from the next cycle. It takes priority over a verify completion in the same cycle.
- R11: start_i is ignored while busy_o=1: the run continues to the last address captured at its start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start request, accepted when idle |
| last_addr_i | input | ADDR_W | Highest address to verify, captured at start |
| abort_i | input | 1 | Abort the run, pins to idle |
| dev_addr_o | output | ADDR_W | Device address |
| dev_data_i | input | 8 | Device read data |
| dev_ce_n_o | output | 1 | Device chip enable, active low |
| dev_oe_n_o | output | 1 | Device output enable, active low |
| dev_a9_hv_o | output | 1 | Enable for the high-voltage level on A9 |
| dev_vpp_hv_o | output | 1 | Enable for the high programming supply |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | Run finished, result valid until next start or abort |
| pass_o | output | 1 | Erase succeeded (valid with done_o) |
| pulse_cnt_o | output | $clog2(MAX_PULSES+1) | Erase pulses applied in this run |

## Verification
An abort and the judgment of the last byte can land on the same clock edge, because `ST_READ` lasts one cycle and both act at its end. The bench provokes this by waiting for the negative edge at which OE is low on the last address, then raising abort at that edge. On the next negative edge it requires done_o=0, busy_o=0 and an idle pin port, which shows that abort wins over the success report. A start request during a busy run is also driven with a different last address, and the read count proves that it was ignored.

// File: rtl/erase_seq_pkg.sv
package erase_seq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_HV_SETUP,
        ST_PULSE,
        ST_HV_HOLD,
        ST_ADDR_SETUP,
        ST_READ
    } seq_state_e;

    localparam logic [7:0] ERASED_BYTE = 8'hFF;

endpackage

// File: rtl/erase_wait_timer.sv
module erase_wait_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired = (cnt_q == '0);

endmodule

// File: rtl/erase_verify_cursor.sv
module erase_verify_cursor #(
    parameter int ADDR_W = 19,
    parameter int PC_W   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              addr_inc,
    input  logic              pulse_inc,
    output logic [ADDR_W-1:0] addr,
    output logic [PC_W-1:0]   pulse_cnt
);

    // The address is only advanced on a passing byte, so after a failure it
    // already points at the byte where the next pass must resume.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr      <= '0;
            pulse_cnt <= '0;
        end else if (clear) begin
            addr      <= '0;
            pulse_cnt <= '0;
        end else begin
            if (addr_inc) begin
                addr <= addr + 1'b1;
            end
            if (pulse_inc) begin
                pulse_cnt <= pulse_cnt + 1'b1;
            end
        end
    end

endmodule

// File: rtl/chip_erase_sequencer.sv
module chip_erase_sequencer
    import erase_seq_pkg::*;
#(
    parameter int ADDR_W     = 19,
    parameter int PULSE_CYC  = 25_000_000,
    parameter int SETUP_CYC  = 100,
    parameter int HOLD_CYC   = 100,
    parameter int MAX_PULSES = 10,
    localparam int PC_W      = $clog2(MAX_PULSES + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [ADDR_W-1:0] last_addr_i,
    input  logic              abort_i,
    output logic [ADDR_W-1:0] dev_addr_o,
    input  logic [7:0]        dev_data_i,
    output logic              dev_ce_n_o,
    output logic              dev_oe_n_o,
    output logic              dev_a9_hv_o,
    output logic              dev_vpp_hv_o,
    output logic              busy_o,
    output logic              done_o,
    output logic              pass_o,
    output logic [PC_W-1:0]   pulse_cnt_o
);

    localparam int LONG_AB = (PULSE_CYC > SETUP_CYC) ? PULSE_CYC : SETUP_CYC;
    localparam int LONGEST = (LONG_AB > HOLD_CYC) ? LONG_AB : HOLD_CYC;
    localparam int TMR_W   = $clog2(LONGEST + 1);

    seq_state_e        state_q, state_d;
    logic [ADDR_W-1:0] last_q;
    logic              done_q, pass_q;
    logic              clear, addr_inc, pulse_inc, finish, fin_pass;
    logic              tmr_load, tmr_expired;
    logic [TMR_W-1:0]  tmr_val;
    logic [ADDR_W-1:0] cur_addr;
    logic [PC_W-1:0]   pulse_cnt;

    erase_wait_timer #(.CNT_W(TMR_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_expired)
    );

    erase_verify_cursor #(.ADDR_W(ADDR_W), .PC_W(PC_W)) u_cursor (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (clear),
        .addr_inc  (addr_inc),
        .pulse_inc (pulse_inc),
        .addr      (cur_addr),
        .pulse_cnt (pulse_cnt)
    );

    // Next-state and event decode.
    always_comb begin
        state_d   = state_q;
        clear     = 1'b0;
        addr_inc  = 1'b0;
        pulse_inc = 1'b0;
        finish    = 1'b0;
        fin_pass  = 1'b0;
        if (abort_i) begin
            state_d = ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (start_i) begin
                        state_d = ST_HV_SETUP;
                        clear   = 1'b1;
                    end
                end
                ST_HV_SETUP: begin
                    if (tmr_expired) begin
                        state_d   = ST_PULSE;
                        pulse_inc = 1'b1;
                    end
                end
                ST_PULSE: begin
                    if (tmr_expired) state_d = ST_HV_HOLD;
                end
                ST_HV_HOLD: begin
                    if (tmr_expired) state_d = ST_ADDR_SETUP;
                end
                ST_ADDR_SETUP: begin
                    if (tmr_expired) state_d = ST_READ;
                end
                ST_READ: begin
                    if (dev_data_i == ERASED_BYTE) begin
                        if (cur_addr == last_q) begin
                            state_d  = ST_IDLE;
                            finish   = 1'b1;
                            fin_pass = 1'b1;
                        end else begin
                            state_d  = ST_ADDR_SETUP;
                            addr_inc = 1'b1;
                        end
                    end else if (pulse_cnt >= PC_W'(MAX_PULSES)) begin
                        state_d = ST_IDLE;
                        finish  = 1'b1;
                    end else begin
                        state_d = ST_HV_SETUP;
                    end
                end
                default: state_d = ST_IDLE;
            endcase
        end
    end

    // Wait length for the state being entered.
    always_comb begin
        tmr_load = (state_d != state_q);
        unique case (state_d)
            ST_HV_SETUP:   tmr_val = TMR_W'(SETUP_CYC - 1);
            ST_PULSE:      tmr_val = TMR_W'(PULSE_CYC - 1);
            ST_HV_HOLD:    tmr_val = TMR_W'(HOLD_CYC - 1);
            ST_ADDR_SETUP: tmr_val = TMR_W'(SETUP_CYC - 1);
            default:       tmr_val = '0;
        endcase
    end

    // State register with run result.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            last_q  <= '0;
            done_q  <= 1'b0;
            pass_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            if (abort_i) begin
                done_q <= 1'b0;
                pass_q <= 1'b0;
            end else if (clear) begin
                last_q <= last_addr_i;
                done_q <= 1'b0;
                pass_q <= 1'b0;
            end else if (finish) begin
                done_q <= 1'b1;
                pass_q <= fin_pass;
            end
        end
    end

    // Pin and status outputs from the state register.
    always_comb begin
        dev_ce_n_o   = 1'b1;
        dev_oe_n_o   = 1'b1;
        dev_a9_hv_o  = 1'b0;
        dev_vpp_hv_o = 1'b0;
        unique case (state_q)
            ST_IDLE: ;
            ST_HV_SETUP: begin
                dev_a9_hv_o  = 1'b1;
                dev_vpp_hv_o = 1'b1;
            end
            ST_PULSE: begin
                dev_a9_hv_o  = 1'b1;
                dev_vpp_hv_o = 1'b1;
                dev_ce_n_o   = 1'b0;
            end
            ST_HV_HOLD: begin
                dev_a9_hv_o  = 1'b1;
                dev_vpp_hv_o = 1'b1;
            end
            ST_ADDR_SETUP: begin
                dev_vpp_hv_o = 1'b1;
                dev_ce_n_o   = 1'b0;
            end
            ST_READ: begin
                dev_vpp_hv_o = 1'b1;
                dev_ce_n_o   = 1'b0;
                dev_oe_n_o   = 1'b0;
            end
            default: ;
        endcase
    end

    assign dev_addr_o  = cur_addr;
    assign busy_o      = (state_q != ST_IDLE);
    assign done_o      = done_q;
    assign pass_o      = pass_q;
    assign pulse_cnt_o = pulse_cnt;

endmodule

// File: rtl/erase_seq_checker.sv
module erase_seq_checker #(
    parameter int ADDR_W     = 19,
    parameter int MAX_PULSES = 10,
    parameter int PC_W       = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start_i,
    input logic              abort_i,
    input logic [ADDR_W-1:0] dev_addr_o,
    input logic              dev_ce_n_o,
    input logic              dev_oe_n_o,
    input logic              dev_a9_hv_o,
    input logic              dev_vpp_hv_o,
    input logic              busy_o,
    input logic              done_o,
    input logic [PC_W-1:0]   pulse_cnt_o
);

    // R2
    start_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o && !abort_i) |=> (busy_o && pulse_cnt_o == '0));

    // R3
    pulse_levels_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!dev_ce_n_o && dev_a9_hv_o) |-> (dev_vpp_hv_o && dev_oe_n_o));

    // R4
    a9_rise_ce_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dev_a9_hv_o) |-> dev_ce_n_o);

    // R4
    a9_steady_under_ce_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!dev_ce_n_o && $past(!dev_ce_n_o)) |-> $stable(dev_a9_hv_o));

    // R5
    verify_levels_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !dev_oe_n_o |-> (!dev_a9_hv_o && dev_vpp_hv_o && !dev_ce_n_o));

    // R5
    read_addr_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dev_oe_n_o) |-> $stable(dev_addr_o));

    // R8
    done_pins_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (dev_ce_n_o && dev_oe_n_o && !dev_a9_hv_o && !dev_vpp_hv_o && !busy_o));

    // R9
    pulse_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pulse_cnt_o <= PC_W'(MAX_PULSES));

    // R10
    abort_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        abort_i |=> (dev_ce_n_o && dev_oe_n_o && !dev_a9_hv_o && !dev_vpp_hv_o
                     && !busy_o && !done_o));

endmodule

bind chip_erase_sequencer erase_seq_checker #(
    .ADDR_W     (ADDR_W),
    .MAX_PULSES (MAX_PULSES),
    .PC_W       (PC_W)
) i_erase_seq_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_i      (start_i),
    .abort_i      (abort_i),
    .dev_addr_o   (dev_addr_o),
    .dev_ce_n_o   (dev_ce_n_o),
    .dev_oe_n_o   (dev_oe_n_o),
    .dev_a9_hv_o  (dev_a9_hv_o),
    .dev_vpp_hv_o (dev_vpp_hv_o),
    .busy_o       (busy_o),
    .done_o       (done_o),
    .pulse_cnt_o  (pulse_cnt_o)
);

// File: tb/test_chip_erase_sequencer.sv
`timescale 1ns/1ps
module test_chip_erase_sequencer;

    localparam int AW    = 6;
    localparam int PCYC  = 20;
    localparam int SCYC  = 3;
    localparam int HCYC  = 4;
    localparam int MAXP  = 5;
    localparam int PCW   = $clog2(MAXP + 1);
    localparam int DEPTH = 1 << AW;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           start = 1'b0;
    logic [AW-1:0]  last_addr = '0;
    logic           abort = 1'b0;
    logic [AW-1:0]  dev_addr;
    logic [7:0]     dev_data;
    logic           ce_n, oe_n, a9_hv, vpp_hv;
    logic           busy, done, pass;
    logic [PCW-1:0] pcnt;

    int errors = 0;
    int checks = 0;

    always #10 clk = ~clk;

    chip_erase_sequencer #(
        .ADDR_W(AW), .PULSE_CYC(PCYC), .SETUP_CYC(SCYC),
        .HOLD_CYC(HCYC), .MAX_PULSES(MAXP)
    ) i_chip_erase_sequencer (
        .clk(clk), .rst_n(rst_n), .start_i(start), .last_addr_i(last_addr),
        .abort_i(abort), .dev_addr_o(dev_addr), .dev_data_i(dev_data),
        .dev_ce_n_o(ce_n), .dev_oe_n_o(oe_n), .dev_a9_hv_o(a9_hv),
        .dev_vpp_hv_o(vpp_hv), .busy_o(busy), .done_o(done), .pass_o(pass),
        .pulse_cnt_o(pcnt)
    );

    // Device model: a byte reads FFh once it has received need_mem pulses.
    int need_mem [DEPTH];
    int applied;
    assign dev_data = (!ce_n && !oe_n) ?
                      ((applied >= need_mem[dev_addr]) ? 8'hFF : 8'hF7) : 8'h00;

    // Pin monitor
    logic mon_clr = 1'b0;
    int pulses_seen, setup_bad, plen_bad, hold_bad, oe_bad, pre_bad;
    int read_n, seq_bad, resume_n;
    int resume_log [16];
    int a9_pre, plen, hold_cnt, addr_stable, last_read;
    bit in_pulse, holding, pulse_since_read;
    logic prev_oe_n;
    logic [AW-1:0] prev_addr;

    always @(negedge clk) begin
        if (mon_clr) begin
            pulses_seen = 0; setup_bad = 0; plen_bad = 0; hold_bad = 0;
            oe_bad = 0; pre_bad = 0; read_n = 0; seq_bad = 0; resume_n = 0;
            a9_pre = 0; plen = 0; hold_cnt = 0; addr_stable = 0; last_read = 0;
            in_pulse = 0; holding = 0; pulse_since_read = 0; applied = 0;
            prev_oe_n = 1'b1; prev_addr = '0;
        end else begin
            if (a9_hv && !ce_n && !in_pulse) begin
                pulses_seen++; applied++;
                if (a9_pre < SCYC) setup_bad++;
                plen = 1; in_pulse = 1; pulse_since_read = 1;
            end else if (a9_hv && !ce_n) begin
                plen++;
            end
            if (!(a9_hv && !ce_n) && in_pulse) begin
                if (plen != PCYC) plen_bad++;
                in_pulse = 0; holding = 1;
                hold_cnt = (a9_hv && ce_n) ? 1 : 0;
            end else if (holding) begin
                if (a9_hv && ce_n) hold_cnt++;
                else begin
                    if (hold_cnt < HCYC) hold_bad++;
                    holding = 0;
                end
            end
            a9_pre = (a9_hv && ce_n) ? a9_pre + 1 : 0;
            if (pulses_seen == 0 && (!ce_n || !oe_n)) pre_bad++;
            if (prev_oe_n && !oe_n) begin
                if (addr_stable < SCYC || a9_hv || !vpp_hv) oe_bad++;
                read_n++;
                if (pulse_since_read) begin
                    if (resume_n < 16) resume_log[resume_n] = int'(dev_addr);
                    resume_n++;
                    pulse_since_read = 0;
                end else if (int'(dev_addr) != last_read + 1) begin
                    seq_bad++;
                end
                last_read = int'(dev_addr);
            end
            if (!ce_n && oe_n && !a9_hv)
                addr_stable = (dev_addr == prev_addr) ? addr_stable + 1 : 1;
            else
                addr_stable = 0;
            prev_oe_n = oe_n;
            prev_addr = dev_addr;
        end
    end

    // Watchdog
    int cyc = 0;
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("  Result: errors=%0d of %0d checks", errors + 1, checks + 1);
            $finish;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic pins_idle(input string req);
        chk(req, {ce_n, oe_n, a9_hv, vpp_hv, busy}, 5'b11000);
    endtask

    task automatic set_need(input int dflt);
        for (int i = 0; i < DEPTH; i++) need_mem[i] = dflt;
    endtask

    // Clears the monitor, issues start and checks the first cycle after it.
    task automatic launch(input int last);
        @(negedge clk); mon_clr = 1'b1;
        @(negedge clk); mon_clr = 1'b0;
        last_addr = AW'(last); start = 1'b1;
        @(negedge clk); start = 1'b0;
        chk("R2 busy after start", int'(busy), 1);
        chk("R2 count cleared", int'(pcnt), 0);
        chk("R2 hv on ce high", {a9_hv, vpp_hv, ce_n}, 3'b111);
    endtask

    task automatic wait_done();
        while (!done) @(negedge clk);
    endtask

    task automatic chk_timing(input string tag);
        chk({tag, " R3 pulse width"}, plen_bad, 0);
        chk({tag, " R4 a9 setup"}, setup_bad, 0);
        chk({tag, " R4 a9 hold"}, hold_bad, 0);
        chk({tag, " R5 oe setup"}, oe_bad, 0);
        chk({tag, " R2 no access before pulse"}, pre_bad, 0);
    endtask

    task automatic t_reset();
        pins_idle("R1 reset pins");
        chk("R1 reset done/pass/count", {done, pass, 4'(pcnt)}, 0);
    endtask

    task automatic t_clean_pass();
        set_need(1);
        launch(15);
        repeat (40) @(negedge clk);
        last_addr = AW'(40); start = 1'b1;   // R11: ignored while busy
        @(negedge clk); start = 1'b0;
        wait_done();
        chk("R8 pass", int'(pass), 1);
        chk("R8 count", int'(pcnt), 1);
        pins_idle("R8 idle after pass");
        chk("R3 one pulse", pulses_seen, 1);
        chk("R6 first read at 0", resume_log[0], 0);
        chk("R6 ascending", seq_bad, 0);
        chk("R11 read count", read_n, 16);
        chk_timing("clean");
    endtask

    task automatic t_resume();
        set_need(1);
        need_mem[5] = 2;
        need_mem[9] = 3;
        launch(12);
        wait_done();
        chk("R7 pass", int'(pass), 1);
        chk("R7 count", int'(pcnt), 3);
        chk("R7 resume count", resume_n, 3);
        chk("R7 resume 1", resume_log[1], 5);
        chk("R7 resume 2", resume_log[2], 9);
        chk("R7 total reads", read_n, 15);
        chk("R6 ascending", seq_bad, 0);
        chk_timing("resume");
    endtask

    task automatic t_give_up();
        set_need(1);
        need_mem[3] = 9;
        launch(7);
        wait_done();
        chk("R9 fail", int'(pass), 0);
        chk("R9 count", int'(pcnt), MAXP);
        chk("R9 pulses", pulses_seen, MAXP);
        chk("R9 reads", read_n, 4 + (MAXP - 1));
        pins_idle("R9 idle after fail");
        repeat (40) @(negedge clk);
        chk("R9 no extra pulse", pulses_seen, MAXP);
    endtask

    task automatic t_exact_max();
        set_need(1);
        need_mem[0] = MAXP;
        launch(3);
        wait_done();
        chk("R9 pass on last pulse", int'(pass), 1);
        chk("R9 count at last", int'(pcnt), MAXP);
    endtask

    task automatic t_abort_pulse();
        set_need(1);
        launch(10);
        while (!(a9_hv && !ce_n)) @(negedge clk);
        abort = 1'b1;
        @(negedge clk); abort = 1'b0;
        pins_idle("R10 abort in pulse");
        chk("R10 done low", int'(done), 0);
    endtask

    task automatic t_abort_vs_finish();
        set_need(1);
        launch(2);
        while (!(!oe_n && dev_addr == AW'(2))) @(negedge clk);
        abort = 1'b1;
        @(negedge clk); abort = 1'b0;
        pins_idle("R10 abort beats finish");
        chk("R10 done suppressed", int'(done), 0);
        repeat (5) @(negedge clk);
        chk("R10 stays idle", {int'(busy), int'(done)}, 0);
    endtask

    initial begin
        set_need(1);
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_clean_pass();
        t_resume();
        t_give_up();
        t_exact_max();
        t_abort_pulse();
        t_abort_vs_finish();
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule